// File: doc/BRIEF.md
# Serial DAC Code Loader

This block is the digital front end of a multiplying current-output DAC. A host writes 16-bit words over a three-wire link: an active-low frame sync, a serial clock and a data line. The block shifts each word into a holding register and reads the two leading command bits. When the frame sync is released after a complete word, it either copies the data field into the parallel code register that drives the ladder switches, or changes which serial clock edge samples the data line.

All three serial inputs are brought into one system clock domain through synchronizer stages, and edges are found there. The system clock must run at least four times as fast as the serial clock. Frame sync must stay high for at least four system clock cycles between words. The code width is a parameter (8, 10, 12 or 14 bits), and the data field is left-justified under the command bits. The low bits that a narrower build does not use are dropped.

Top module: `sdac_loader`

## Requirements
- R1: While `rstN` is low, `dacCode` is zero, `risingMode` is 0 and `updatePulse` is 0.
- R2: A word is 16 bits sent most significant bit first. Bits 15:14 carry the command and bits 13:0 the data field. A load sets `dacCode` to the top `RES_BITS` bits of that field, so bits 13 down to 14-`RES_BITS` are used and the lower bits are ignored.
- R3: Command 00 (load) writes the data field into `dacCode`. `dacCode` changes at no other time.
- R4: For a load, `updatePulse` is high for exactly one clock cycle. It starts, together with the new `dacCode`, at the third rising clock edge after the rise of `frameSyncN`.
- R5: Commands 01 and 10 change neither `dacCode` nor `risingMode`, and no pulse is produced.
- R6: Command 11 sets `risingMode` to 1, leaves `dacCode` unchanged and produces no pulse.
- R7: After reset, data is sampled on falling `serClk` edges. Once `risingMode` is 1, data is sampled on rising edges, and it stays that way until the next reset.
- R8: A word that ends with fewer than 16 active edges is discarded. `dacCode` and `risingMode` keep their values.
- R9: Active edges beyond the 16th in a frame are ignored. The first 16 bits form the word.
- R10: `serClk` and `serData` activity while `frameSyncN` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| frameSyncN | input | 1 | Active-low frame sync from the host |
| serClk | input | 1 | Serial clock from the host |
| serData | input | 1 | Serial data, MSB first |
| dacCode | output | RES_BITS | Code register driving the DAC ladder |
| risingMode | output | 1 | 1 when data is sampled on rising serial clock edges |
| updatePulse | output | 1 | One-cycle strobe on each code register load |

## Verification
The only latency that matters at the ports is between the release of frame sync and the update. The bench raises `frameSyncN` just after a falling system clock edge. It then samples `updatePulse` on each of the next six falling edges and requires the pulse on the third one only for loads, and never otherwise. Code and mode are compared only after that window, against values computed from the word that was sent. Each bit is followed by a deliberately wrong data value before the inactive edge, so sampling on the wrong edge shows up as a wrong code.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 2;
  localparam int FIELD_BITS = FRAME_BITS - CMD_BITS;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_LOAD   = 2'b00,
    CMD_SPARE0 = 2'b01,
    CMD_SPARE1 = 2'b10,
    CMD_RISE   = 2'b11
  } cmd_e;

  typedef struct packed {
    logic shiftEn;   // capture one serial bit
    logic commit;    // complete word, frame sync just released
  } strobe_t;

endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameSyncN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    risingMode,
  output strobe_t strobes,
  output logic    serBit
);

  localparam int STG = SYNC_STAGES;
  localparam int CW  = $clog2(FRAME_BITS + 1);

  // index STG-1 is the synchronized value, index STG the previous one
  logic [STG:0] fsPipe, ckPipe, dtPipe;
  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPipe <= '1;
      ckPipe <= '0;
      dtPipe <= '0;
    end else begin
      fsPipe <= {fsPipe[STG-1:0], frameSyncN};
      ckPipe <= {ckPipe[STG-1:0], serClk};
      dtPipe <= {dtPipe[STG-1:0], serData};
    end
  end

  logic fsNow, fsOld, ckNow, ckOld, activeEdge, inFrame, wordFull;

  assign fsNow      = fsPipe[STG-1];
  assign fsOld      = fsPipe[STG];
  assign ckNow      = ckPipe[STG-1];
  assign ckOld      = ckPipe[STG];
  assign serBit     = dtPipe[STG-1];
  assign inFrame    = ~fsNow;
  assign wordFull   = (bitCnt == CW'(FRAME_BITS));
  assign activeEdge = risingMode ? (ckNow & ~ckOld) : (~ckNow & ckOld);

  always_comb begin
    strobes         = '0;
    strobes.shiftEn = inFrame & activeEdge & ~wordFull;
    strobes.commit  = fsNow & ~fsOld & wordFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bitCnt <= '0;
    else if (!inFrame)        bitCnt <= '0;
    else if (strobes.shiftEn) bitCnt <= bitCnt + CW'(1);
  end

endmodule

// File: rtl/sdac_dpath.sv
module sdac_dpath
  import sdac_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic                serBit,
  output logic [RES_BITS-1:0] dacCode,
  output logic                risingMode,
  output logic                updatePulse
);

  localparam int FIELD_MSB = FIELD_BITS - 1;

  logic [FRAME_BITS-1:0] shiftReg;
  cmd_e                  cmd;

  assign cmd = cmd_e'(shiftReg[FRAME_BITS-1 -: CMD_BITS]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_BITS-2:0], serBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode     <= '0;
      risingMode  <= 1'b0;
      updatePulse <= 1'b0;
    end else begin
      updatePulse <= 1'b0;
      if (strobes.commit) begin
        case (cmd)
          CMD_LOAD: begin
            dacCode     <= shiftReg[FIELD_MSB -: RES_BITS];
            updatePulse <= 1'b1;
          end
          CMD_RISE: risingMode <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdac_loader.sv
module sdac_loader
  import sdac_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameSyncN,
  input  logic                serClk,
  input  logic                serData,
  output logic [RES_BITS-1:0] dacCode,
  output logic                risingMode,
  output logic                updatePulse
);

  strobe_t strobes;
  logic    serBit;

  sdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameSyncN (frameSyncN),
    .serClk     (serClk),
    .serData    (serData),
    .risingMode (risingMode),
    .strobes    (strobes),
    .serBit     (serBit)
  );

  sdac_dpath #(.RES_BITS(RES_BITS)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .serBit      (serBit),
    .dacCode     (dacCode),
    .risingMode  (risingMode),
    .updatePulse (updatePulse)
  );

endmodule

// File: rtl/sdac_loader_chk.sv
module sdac_loader_chk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameSyncN,
  input logic [RES_BITS-1:0] dacCode,
  input logic                risingMode,
  input logic                updatePulse
);

  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (dacCode == '0 && !risingMode && !updatePulse)
        else $error("R1: outputs not cleared under reset");
    end
  end

  a_r3_code_moves_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> updatePulse);

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |=> !updatePulse);

  a_r6_switch_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(risingMode) |-> !updatePulse);

  a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rstN)
    risingMode |=> risingMode);

  a_r10_update_outside_frame: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |-> frameSyncN);

endmodule

bind sdac_loader sdac_loader_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameSyncN  (frameSyncN),
  .dacCode     (dacCode),
  .risingMode  (risingMode),
  .updatePulse (updatePulse)
);

// File: tb/test_sdac_loader.sv
module test_sdac_loader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int NRES       = 4;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic fsN = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [13:0] codeOut  [NRES];
  logic        modeOut  [NRES];
  logic        pulseOut [NRES];

  for (genvar g = 0; g < NRES; g++) begin : g_res
    localparam int R = 8 + 2*g;
    logic [R-1:0] code;
    logic         mode, pulse;
    sdac_loader #(.RES_BITS(R)) i_sdac_loader (
      .clk         (clk),
      .rstN        (rstN),
      .frameSyncN  (fsN),
      .serClk      (sck),
      .serData     (sdi),
      .dacCode     (code),
      .risingMode  (mode),
      .updatePulse (pulse)
    );
    assign codeOut[g]  = 14'(code);
    assign modeOut[g]  = mode;
    assign pulseOut[g] = pulse;
  end

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;
  logic [13:0] expCode [NRES];
  bit  expRise;

  function automatic logic [13:0] fieldOf(logic [15:0] f, int g);
    int r = 8 + 2*g;
    logic [13:0] d = f[13:0];
    return d >> (14 - r);
  endfunction

  task automatic check(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    for (int g = 0; g < NRES; g++) begin
      check($sformatf("%s code res%0d", req, 8+2*g), codeOut[g], expCode[g]);
      check($sformatf("%s mode res%0d", req, 8+2*g), modeOut[g], expRise);
    end
  endtask

  task automatic setIdle();
    sck = expRise ? 1'b0 : 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendBits(logic [31:0] bits, int n);
    @(negedge clk);
    fsN = 1'b0;
    repeat (HALF_BIT) @(negedge clk);
    for (int i = n-1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (HALF_BIT) @(negedge clk);
      sck = expRise ? 1'b1 : 1'b0;
      repeat (2) @(negedge clk);
      sdi = ~bits[i];
      repeat (2) @(negedge clk);
      sck = expRise ? 1'b0 : 1'b1;
    end
    repeat (HALF_BIT) @(negedge clk);
  endtask

  // raise frame sync and find on which falling edge each pulse shows
  task automatic raiseAndWatch(bit expectPulse, string req);
    int seen [NRES];
    for (int g = 0; g < NRES; g++) seen[g] = 0;
    fsN = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      for (int g = 0; g < NRES; g++)
        if (pulseOut[g]) seen[g] = (seen[g] == 0) ? k : 99;
    end
    for (int g = 0; g < NRES; g++)
      check($sformatf("%s pulse slot res%0d", req, 8+2*g), seen[g], expectPulse ? 3 : 0);
  endtask

  // full word: model the update, then compare
  task automatic frame(logic [15:0] f, string req);
    sendBits({16'h0, f}, 16);
    if (f[15:14] == 2'b00)
      for (int g = 0; g < NRES; g++) expCode[g] = fieldOf(f, g);
    raiseAndWatch(f[15:14] == 2'b00, req);
    if (f[15:14] == 2'b11) expRise = 1'b1;
    checkState(req);
    setIdle();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int g = 0; g < NRES; g++) begin
      check("R1 code in reset", codeOut[g], 0);
      check("R1 mode in reset", modeOut[g], 0);
      check("R1 pulse in reset", pulseOut[g], 0);
    end
    rstN = 1'b1;
    expRise = 1'b0;
    for (int g = 0; g < NRES; g++) expCode[g] = '0;
    setIdle();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] f;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2741);
    #1 rstN = 1'b0;
    expRise = 1'b0;
    doReset();

    // R2/R3: all ones, then the lowest field bit only seen by the widest build
    frame(16'h3FFF, "R2 all ones");
    frame(16'h0001, "R2 low bit dropped");
    frame(16'h2AAA, "R3 load pattern");
    frame(16'h1557, "R2 load pattern");

    // R5: spare commands
    frame(16'h5555, "R5 cmd 01");
    frame(16'h9234, "R5 cmd 10");

    // random loads and spare commands, falling mode
    for (int i = 0; i < 20; i++) begin
      f = 16'($urandom);
      if (f[15:14] == 2'b11) f[15:14] = 2'b00;
      frame(f, "R3 random falling");
    end

    // R8: short words, one of them shaped like a mode switch
    sendBits(32'h2C5, 10);
    raiseAndWatch(1'b0, "R8 short word");
    checkState("R8 short word");
    setIdle();
    sendBits(32'h7FFF, 15);
    raiseAndWatch(1'b0, "R8 short switch");
    checkState("R8 short switch");
    setIdle();

    // R9: 20 edges, first 16 bits form the word
    f = 16'h1ABC;
    sendBits({12'h0, f, 4'hD}, 20);
    for (int g = 0; g < NRES; g++) expCode[g] = fieldOf(f, g);
    raiseAndWatch(1'b1, "R9 long word");
    checkState("R9 long word");
    setIdle();

    // R10: serial activity with frame sync high
    for (int i = 0; i < 12; i++) begin
      sdi = 1'($urandom);
      sck = ~sck;
      repeat (HALF_BIT) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    for (int g = 0; g < NRES; g++) check("R10 idle pulse", pulseOut[g], 0);
    checkState("R10 idle activity");
    setIdle();

    // R6: switch to rising edge sampling
    frame(16'hC3A5, "R6 mode switch");

    // R7: rising mode loads, repeated switch command
    for (int i = 0; i < 10; i++) begin
      f = 16'($urandom);
      if (f[15:14] == 2'b11) f[15:14] = 2'b00;
      frame(f, "R7 random rising");
    end
    frame(16'hFFFF, "R7 switch again");
    frame(16'h0ACE, "R7 rising load");

    // R7: reset returns to falling edge sampling
    doReset();
    checkState("R7 after reset");
    frame(16'h1234, "R7 falling after reset");
    frame(16'h3F0F, "R7 falling after reset");

    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule